// File: doc/BRIEF.md
# Data-Processing ALU with Flag Logic

This block is the integer execute stage for the sixteen data-processing operations of a 32-bit load/store core. Each cycle the surrounding datapath may present one operation: a 4-bit opcode, the first operand, a second operand, the S bit, the destination register index, the current C and V flags, the current processor mode and the saved status word. The second operand is either a register value that an external barrel shifter has already shifted, together with that shifter's carry-out, or an 8-bit immediate plus a 4-bit rotate field. The block rotates the immediate itself.

The block computes the result and the new N, Z, C and V flags. It decides whether the destination register and the flags are written. It also handles the special case where S is set and the destination is the program counter. In that case the saved status word is handed back as the new current status word, unless the core is in User mode or the saved mode field is not a legal mode. Either of those raises an error pulse instead. All outputs are registered. An operation accepted on a clock edge with `valid_i` high shows its effects right after that edge. The write strobes are single-cycle pulses.

Top module: `dp_alu_unit`

## Requirements
- R1: Opcodes 0 AND, 1 EOR, 12 ORR, 13 MOV, 14 BIC and 15 MVN give op1&op2, op1^op2, op1|op2, op2, op1&~op2 and ~op2 on `res_o`.
- R2: Opcodes 2 SUB and 10 CMP compute op1+~op2+1. Opcode 3 RSB computes ~op1+op2+1. Opcodes 4 ADD and 11 CMN compute op1+op2. Opcode 5 ADC adds C. Opcode 6 SBC and opcode 7 RSC use the incoming C as carry-in in place of 1.
- R3: For the arithmetic opcodes, the new C is the carry out of bit 31 of that addition, so a subtraction that borrows clears C. The new V is the signed overflow of the addition.
- R4: For the logical opcodes (0, 1, 8, 9, 12 to 15), the new V equals `v_in_i`. With a register operand the new C equals `shc_i`.
- R5: With `imm_sel_i` high, op2 is `imm8_i` rotated right by twice `rot_i`. The new C is bit 31 of that value when `rot_i` is nonzero, and `c_in_i` when it is zero.
- R6: `flags_o` is {N,Z,C,V} in bits 3..0. N is bit 31 of the result, and Z is set exactly when the 32-bit result is zero.
- R7: Opcodes 8 TST, 9 TEQ, 10 CMP and 11 CMN never raise `rd_we_o`, but they update the flags when S is set.
- R8: With S clear, `flags_we_o` stays low and `flags_o` keeps its previous value.
- R9: With S set and `rd_idx_i` equal to 15, `cpsr_load_o` pulses with `cpsr_val_o` equal to `spsr_i` and `flags_we_o` stays low. The destination write still follows R7.
- R10: That restore instead pulses `err_o`, with no register, flag or status write, when `mode_i` is User (5'b10000). It does the same when `spsr_i[4:0]` is none of 10000, 10001, 10010, 10011, 10111, 11011 or 11111.
- R11: When `valid_i` or `cond_pass_i` is low at an edge, no strobe rises and `res_o` and `flags_o` hold.
- R12: Synchronous active-high reset clears all outputs. Results appear one clock after the operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| cond_pass_i | input | 1 | Condition field passed |
| opcode_i | input | 4 | Data-processing opcode |
| s_bit_i | input | 1 | Set-flags bit |
| rd_idx_i | input | 4 | Destination register index |
| op1_i | input | 32 | First operand |
| imm_sel_i | input | 1 | Use rotated immediate as op2 |
| imm8_i | input | 8 | Immediate byte |
| rot_i | input | 4 | Immediate rotate field (rotation = 2*rot) |
| op2_reg_i | input | 32 | Shifted register operand |
| shc_i | input | 1 | Shifter carry-out for register operand |
| c_in_i | input | 1 | Current C flag |
| v_in_i | input | 1 | Current V flag |
| mode_i | input | 5 | Current processor mode |
| spsr_i | input | 32 | Saved status word |
| res_o | output | 32 | Registered result |
| rd_we_o | output | 1 | Destination write pulse |
| flags_we_o | output | 1 | Flag write pulse |
| flags_o | output | 4 | Last written {N,Z,C,V} |
| cpsr_load_o | output | 1 | Status restore pulse |
| cpsr_val_o | output | 32 | Status word to restore |
| err_o | output | 1 | Illegal restore pulse |

## Verification
The bench goes after the carry sense of subtraction. A design that treats C as a borrow would report C set on 5-7 and clear on 7-5. It runs the signed-overflow edges 0x7FFFFFFF+1 and 0x80000000-1, where a wrong V rule misses the sign flip, and 0xFFFFFFFF+1, which must give Z and C together. For immediates it checks both a nonzero rotate, where C must come from bit 31 of the rotated value, and a zero rotate, where C must keep its old value; a design that always takes one source fails one of the two. The restore path is exercised in a privileged mode, in User mode and with an illegal saved mode, so a design that skips either guard would load a bad status word. Compare opcodes, clear S and a failed condition each confirm that the register write, the flags and the held result stay untouched.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } dp_op_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  function automatic logic op_is_arith(input logic [3:0] op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: op_is_arith = 1'b1;
      default: op_is_arith = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_compare(input logic [3:0] op);
    op_is_compare = (op[3:2] == 2'b10);
  endfunction

  function automatic logic mode_legal(input logic [4:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SYS: mode_legal = 1'b1;
      default: mode_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dp_imm_rot.sv
module dp_imm_rot #(
  parameter int W  = 32,
  parameter int IW = 8,
  parameter int RW = 4
) (
  input  logic [IW-1:0] imm_i,
  input  logic [RW-1:0] rot_i,
  input  logic          c_cur_i,
  output logic [W-1:0]  val_o,
  output logic          c_o
);
  localparam int SHW = RW + 1;

  logic [W-1:0]   base;
  logic [2*W-1:0] dbl;
  logic [2*W-1:0] shifted;
  logic [SHW-1:0] amt;

  always_comb begin
    base    = {{(W-IW){1'b0}}, imm_i};
    dbl     = {base, base};
    amt     = {rot_i, 1'b0};
    shifted = dbl >> amt;
    val_o   = shifted[W-1:0];
    c_o     = (rot_i != '0) ? val_o[W-1] : c_cur_i;
  end
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_cur_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1;    end
      OP_RSB:         begin x = ~a_i; cin = 1'b1;    end
      OP_ADC:         begin cin = c_cur_i;           end
      OP_SBC:         begin y = ~b_i; cin = c_cur_i; end
      OP_RSC:         begin x = ~a_i; cin = c_cur_i; end
      default:        begin cin = 1'b0;              end
    endcase
    full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum_o = full[W-1:0];
    c_o   = full[W];
    v_o   = (x[W-1] == y[W-1]) && (sum_o[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dp_logic.sv
module dp_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_unit.sv
module dp_alu_unit
  import dp_alu_pkg::*;
#(
  parameter int W      = 32,
  parameter int IW     = 8,
  parameter int ROTW   = 4,
  parameter int RIW    = 4,
  parameter int MW     = 5,
  parameter int PC_IDX = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic            cond_pass_i,
  input  logic [3:0]      opcode_i,
  input  logic            s_bit_i,
  input  logic [RIW-1:0]  rd_idx_i,
  input  logic [W-1:0]    op1_i,
  input  logic            imm_sel_i,
  input  logic [IW-1:0]   imm8_i,
  input  logic [ROTW-1:0] rot_i,
  input  logic [W-1:0]    op2_reg_i,
  input  logic            shc_i,
  input  logic            c_in_i,
  input  logic            v_in_i,
  input  logic [MW-1:0]   mode_i,
  input  logic [W-1:0]    spsr_i,
  output logic [W-1:0]    res_o,
  output logic            rd_we_o,
  output logic            flags_we_o,
  output logic [3:0]      flags_o,
  output logic            cpsr_load_o,
  output logic [W-1:0]    cpsr_val_o,
  output logic            err_o
);
  localparam logic [RIW-1:0] PC_SEL = RIW'(PC_IDX);

  logic [W-1:0] imm_val, op2, arith_res, logic_res, res_n;
  logic         imm_c, op2_c, arith_c, arith_v;
  logic         is_arith, is_cmp, rd_is_pc, restore, bad_restore, exec;
  logic [3:0]   flags_n;

  dp_imm_rot #(.W(W), .IW(IW), .RW(ROTW)) u_rot (
    .imm_i   (imm8_i),
    .rot_i   (rot_i),
    .c_cur_i (c_in_i),
    .val_o   (imm_val),
    .c_o     (imm_c)
  );

  assign op2   = imm_sel_i ? imm_val : op2_reg_i;
  assign op2_c = imm_sel_i ? imm_c   : shc_i;

  dp_addsub #(.W(W)) u_add (
    .op_i    (opcode_i),
    .a_i     (op1_i),
    .b_i     (op2),
    .c_cur_i (c_in_i),
    .sum_o   (arith_res),
    .c_o     (arith_c),
    .v_o     (arith_v)
  );

  dp_logic #(.W(W)) u_log (
    .op_i  (opcode_i),
    .a_i   (op1_i),
    .b_i   (op2),
    .res_o (logic_res)
  );

  always_comb begin
    is_arith    = op_is_arith(opcode_i);
    is_cmp      = op_is_compare(opcode_i);
    rd_is_pc    = (rd_idx_i == PC_SEL);
    exec        = valid_i && cond_pass_i;
    restore     = s_bit_i && rd_is_pc;
    bad_restore = restore &&
                  ((mode_i == MODE_USR) || !mode_legal(spsr_i[4:0]));
    res_n       = is_arith ? arith_res : logic_res;
    flags_n[3]  = res_n[W-1];
    flags_n[2]  = (res_n == '0);
    flags_n[1]  = is_arith ? arith_c : op2_c;
    flags_n[0]  = is_arith ? arith_v : v_in_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      rd_we_o     <= 1'b0;
      flags_we_o  <= 1'b0;
      flags_o     <= '0;
      cpsr_load_o <= 1'b0;
      cpsr_val_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      rd_we_o     <= exec && !is_cmp && !bad_restore;
      flags_we_o  <= exec && s_bit_i && !rd_is_pc;
      cpsr_load_o <= exec && restore && !bad_restore;
      err_o       <= exec && bad_restore;
      if (exec && !bad_restore) begin
        res_o <= res_n;
      end
      if (exec && s_bit_i && !rd_is_pc) begin
        flags_o <= flags_n;
      end
      if (exec && restore && !bad_restore) begin
        cpsr_val_o <= spsr_i;
      end
    end
  end
endmodule

// File: rtl/dp_alu_unit_chk.sv
module dp_alu_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid_i,
  input logic         cond_pass_i,
  input logic [3:0]   opcode_i,
  input logic         s_bit_i,
  input logic [W-1:0] res_o,
  input logic         rd_we_o,
  input logic         flags_we_o,
  input logic [3:0]   flags_o,
  input logic         cpsr_load_o,
  input logic         err_o
);
  // R7
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && opcode_i[3:2] == 2'b10) |=> !rd_we_o);

  // R8
  no_s_flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !s_bit_i) |=> (!flags_we_o && $stable(flags_o)));

  // R6
  zn_match_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we_o |-> ((flags_o[2] == (res_o == '0)) && (flags_o[3] == res_o[W-1])));

  // R9
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flags_we_o, cpsr_load_o, err_o}));

  // R10
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !rd_we_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_i || !cond_pass_i) |=> (!rd_we_o && !flags_we_o && !cpsr_load_o && !err_o && $stable(res_o)));
endmodule

bind dp_alu_unit dp_alu_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .valid_i     (valid_i),
  .cond_pass_i (cond_pass_i),
  .opcode_i    (opcode_i),
  .s_bit_i     (s_bit_i),
  .res_o       (res_o),
  .rd_we_o     (rd_we_o),
  .flags_we_o  (flags_we_o),
  .flags_o     (flags_o),
  .cpsr_load_o (cpsr_load_o),
  .err_o       (err_o)
);

// File: tb/sim_dp_alu_unit.sv
`timescale 1ns/1ps
module sim_dp_alu_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0, cond_pass_i = 1'b1;
  logic [3:0]  opcode_i = '0;
  logic        s_bit_i = 1'b0;
  logic [3:0]  rd_idx_i = 4'd1;
  logic [31:0] op1_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [7:0]  imm8_i = '0;
  logic [3:0]  rot_i = '0;
  logic [31:0] op2_reg_i = '0;
  logic        shc_i = 1'b0, c_in_i = 1'b0, v_in_i = 1'b0;
  logic [4:0]  mode_i = 5'b10011;
  logic [31:0] spsr_i = '0;
  logic [31:0] res_o, cpsr_val_o;
  logic        rd_we_o, flags_we_o, cpsr_load_o, err_o;
  logic [3:0]  flags_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_alu_unit u0 (
    .clk(clk), .rst(rst), .valid_i(valid_i), .cond_pass_i(cond_pass_i),
    .opcode_i(opcode_i), .s_bit_i(s_bit_i), .rd_idx_i(rd_idx_i), .op1_i(op1_i),
    .imm_sel_i(imm_sel_i), .imm8_i(imm8_i), .rot_i(rot_i), .op2_reg_i(op2_reg_i),
    .shc_i(shc_i), .c_in_i(c_in_i), .v_in_i(v_in_i), .mode_i(mode_i), .spsr_i(spsr_i),
    .res_o(res_o), .rd_we_o(rd_we_o), .flags_we_o(flags_we_o), .flags_o(flags_o),
    .cpsr_load_o(cpsr_load_o), .cpsr_val_o(cpsr_val_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    valid_i = 1'b1;
    @(posedge clk); #1;
    valid_i = 1'b0;
  endtask

  task automatic reg_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic s, input logic c, input logic v, input logic sc);
    opcode_i = op; op1_i = a; op2_reg_i = b; s_bit_i = s; c_in_i = c; v_in_i = v;
    shc_i = sc; imm_sel_i = 1'b0; rd_idx_i = 4'd1; cond_pass_i = 1'b1;
    step();
  endtask

  task automatic t_reset();
    chk("R12", "res", res_o, 32'h0);
    chk("R12", "strobes", {28'h0, rd_we_o, flags_we_o, cpsr_load_o, err_o}, 32'h0);
    chk("R12", "flags", {28'h0, flags_o}, 32'h0);
  endtask

  task automatic t_logical();
    reg_op(4'd0, 32'h0000F0F0, 32'h0000FF00, 1, 0, 1, 1);
    chk("R1", "AND", res_o, 32'h0000F000);
    chk("R4", "AND flags", {28'h0, flags_o}, 32'h3);
    reg_op(4'd1, 32'h0000AAAA, 32'h0000FFFF, 1, 1, 0, 0);
    chk("R1", "EOR", res_o, 32'h00005555);
    chk("R4", "EOR C from shifter", {28'h0, flags_o}, 32'h0);
    reg_op(4'd12, 32'h00000F00, 32'h000000F0, 0, 0, 0, 0);
    chk("R1", "ORR", res_o, 32'h00000FF0);
    reg_op(4'd14, 32'h0000FFFF, 32'h000000FF, 0, 0, 0, 0);
    chk("R1", "BIC", res_o, 32'h0000FF00);
    reg_op(4'd15, 32'h12345678, 32'h0, 1, 0, 0, 0);
    chk("R1", "MVN", res_o, 32'hFFFFFFFF);
    chk("R6", "MVN N", {28'h0, flags_o}, 32'h8);
    reg_op(4'd13, 32'h12345678, 32'h0, 1, 1, 0, 0);
    chk("R1", "MOV", res_o, 32'h0);
    chk("R6", "MOV Z", {28'h0, flags_o}, 32'h4);
  endtask

  task automatic t_arith();
    reg_op(4'd4, 32'hFFFFFFFF, 32'h1, 1, 0, 0, 0);
    chk("R2", "ADD wrap", res_o, 32'h0);
    chk("R3", "ADD carry+Z", {28'h0, flags_o}, 32'h6);
    reg_op(4'd4, 32'h7FFFFFFF, 32'h1, 1, 0, 0, 0);
    chk("R3", "ADD overflow", {28'h0, flags_o}, 32'h9);
    reg_op(4'd2, 32'd5, 32'd7, 1, 1, 0, 1);
    chk("R2", "SUB borrow", res_o, 32'hFFFFFFFE);
    chk("R3", "SUB borrow clears C", {28'h0, flags_o}, 32'h8);
    reg_op(4'd2, 32'd7, 32'd5, 1, 0, 0, 0);
    chk("R3", "SUB no borrow sets C", {28'h0, flags_o}, 32'h2);
    reg_op(4'd2, 32'h80000000, 32'h1, 1, 0, 0, 0);
    chk("R3", "SUB overflow", {28'h0, flags_o}, 32'h3);
    reg_op(4'd3, 32'd3, 32'd10, 1, 0, 0, 0);
    chk("R2", "RSB", res_o, 32'd7);
    reg_op(4'd5, 32'd1, 32'd2, 1, 1, 0, 0);
    chk("R2", "ADC", res_o, 32'd4);
    reg_op(4'd6, 32'd10, 32'd3, 1, 0, 0, 0);
    chk("R2", "SBC C=0", res_o, 32'd6);
    reg_op(4'd7, 32'd3, 32'd10, 1, 1, 0, 0);
    chk("R2", "RSC C=1", res_o, 32'd7);
  endtask

  task automatic t_immediate();
    opcode_i = 4'd13; imm_sel_i = 1'b1; imm8_i = 8'hFF; rot_i = 4'd4;
    s_bit_i = 1; c_in_i = 0; v_in_i = 0; rd_idx_i = 4'd1; step();
    chk("R5", "imm rot8", res_o, 32'hFF000000);
    chk("R5", "imm rot C", {28'h0, flags_o}, 32'hA);
    imm8_i = 8'h01; rot_i = 4'd1; c_in_i = 1; step();
    chk("R5", "imm rot2", res_o, 32'h40000000);
    chk("R5", "imm rot clears C", {28'h0, flags_o}, 32'h0);
    imm8_i = 8'h00; rot_i = 4'd0; c_in_i = 1; step();
    chk("R5", "zero rot keeps C", {28'h0, flags_o}, 32'h6);
    imm_sel_i = 1'b0;
  endtask

  task automatic t_compare();
    opcode_i = 4'd10; op1_i = 32'd5; op2_reg_i = 32'd5; s_bit_i = 1; rd_idx_i = 4'd3;
    c_in_i = 0; v_in_i = 0; step();
    chk("R7", "CMP no rd write", {31'h0, rd_we_o}, 32'h0);
    chk("R7", "CMP flags written", {31'h0, flags_we_o}, 32'h1);
    chk("R7", "CMP flags", {28'h0, flags_o}, 32'h6);
  endtask

  task automatic t_no_s();
    reg_op(4'd4, 32'd1, 32'd1, 0, 0, 1, 0);
    chk("R8", "no flag write", {31'h0, flags_we_o}, 32'h0);
    chk("R8", "flags held", {28'h0, flags_o}, 32'h6);
    chk("R8", "rd written", {31'h0, rd_we_o}, 32'h1);
  endtask

  task automatic t_restore();
    opcode_i = 4'd13; op2_reg_i = 32'h1234; s_bit_i = 1; rd_idx_i = 4'd15;
    mode_i = 5'b10011; spsr_i = 32'h600000D3; step();
    chk("R9", "load pulse", {31'h0, cpsr_load_o}, 32'h1);
    chk("R9", "load value", cpsr_val_o, 32'h600000D3);
    chk("R9", "rd and no flags", {30'h0, rd_we_o, flags_we_o}, 32'h2);
    mode_i = 5'b10000; step();
    chk("R10", "user err", {29'h0, err_o, cpsr_load_o, rd_we_o}, 32'h4);
    mode_i = 5'b10011; spsr_i = 32'h00000015; op2_reg_i = 32'h9999; step();
    chk("R10", "bad spsr err", {29'h0, err_o, cpsr_load_o, rd_we_o}, 32'h4);
    chk("R10", "res untouched", res_o, 32'h1234);
    rd_idx_i = 4'd1; spsr_i = '0;
  endtask

  task automatic t_cond_fail();
    cond_pass_i = 1'b0;
    opcode_i = 4'd4; op1_i = 32'd9; op2_reg_i = 32'd9; s_bit_i = 1; step();
    chk("R11", "no strobes", {28'h0, rd_we_o, flags_we_o, cpsr_load_o, err_o}, 32'h0);
    chk("R11", "res held", res_o, 32'h1234);
    chk("R11", "flags held", {28'h0, flags_o}, 32'h6);
    cond_pass_i = 1'b1;
    @(posedge clk); #1;
    chk("R11", "idle no strobes", {28'h0, rd_we_o, flags_we_o, cpsr_load_o, err_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_logical();
    t_arith();
    t_immediate();
    t_compare();
    t_no_s();
    t_restore();
    t_cond_fail();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule